// File: doc/BRIEF.md
# System Interrupt Priority Mapper

This block gathers a set of peripheral interrupt lines (64 by default, organised as two 32-bit banks) and turns them into one request line for each of seven general-purpose core priority levels, numbered 7 through 13.

Each source has its own mask bit and its own 4-bit routing field. A source counts as pending only when its input is high and its mask bit is set. A pending source drives the request line of the level its field names. Field values 0 to 6 select levels 7 to 13, and larger values route the source nowhere.

When the core takes an interrupt at some level, it presents that level on the lookup port. The block answers in the same cycle with the lowest-numbered pending source routed to that level. If no such source exists, it raises a spurious flag and bumps a saturating counter.

Software reaches the registers through a single-cycle, word-addressed write strobe and a combinational read port. The map has these registers:

- mask banks at addresses 0 and 1;
- read-only status banks at 2 and 3;
- wakeup-enable banks at 4 and 5;
- the spurious count at 6;
- eight routing registers at 8 through 15.

Top module: `sip_mapper`

## Requirements
- R1: After reset every mask bit, every routing field, every wakeup bit and the spurious count read 0, and all request lines are low.
- R2: The routing field of source n lives in the register at address 8 + n/8, in bits (n mod 8)*4+3 down to (n mod 8)*4.
- R3: A routing value v in the range 0..6 sends a pending source to level 7+v, which is request bit v. The reset value 0 therefore selects level 7 (bit 0).
- R4: A routing value of 7 or more leaves a pending source off every request line.
- R5: A source whose mask bit is 0 raises no request, whatever its input does.
- R6: Request lines are registered. A change in a source input or a mask bit shows on `irq_req` one clock edge later, and not before.
- R7: When several pending sources share the queried level, the lookup returns the lowest source index.
- R8: A lookup at a level with no pending source routed to it sets `lk_spurious` and clears `lk_found`, and each such cycle adds 1 to the spurious count, which stops at its all-ones value (255). A lookup that finds a source leaves the count unchanged.
- R9: The status registers (address 2 for sources 0..31, address 3 for 32..63) return the live source inputs, and writes to them have no effect.
- R10: The wakeup-enable registers at addresses 4 and 5 are readable and writable, and a single write of all ones sets every bit of a bank.
- R11: Sources 32..63 appear in bank 1 (mask address 1, status address 3) at bit n-32; sources 0..31 appear in bank 0 at bit n.
- R12: A lookup naming a level outside 7..13 always reports spurious.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_in | input | 64 | Peripheral interrupt lines, active high, level sensitive |
| bus_we | input | 1 | Register write strobe, one word per cycle |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr` (combinational) |
| irq_req | output | 7 | Request per level, bit v is level 7+v, registered |
| lk_valid | input | 1 | Lookup strobe |
| lk_level | input | 4 | Level being looked up (7..13 valid) |
| lk_found | output | 1 | Lookup found a pending source |
| lk_src | output | 6 | Index of the source found |
| lk_spurious | output | 1 | Lookup found no pending source |

## Verification
The checker assumes that `src_in` is already synchronous to `clk`, because the block adds no synchronizer. The counter properties assume the spurious count changes only through lookups, since it has no write path. The lookup properties hold for any `lk_level` value, including values outside the legal range. The stimulus changes every input on the falling edge of the clock, so the properties never see a source change between the edges at which they sample.

// File: rtl/sip_pkg.sv
// Package: shared sizes and register address map of the interrupt priority mapper.
// Assumes a bank width equal to the data bus width.
package sip_pkg;
    localparam int SRC_N       = 64;   // interrupt sources
    localparam int BANK_W      = 32;   // bits per mask/status/wake bank
    localparam int DATA_W      = 32;   // register bus width
    localparam int ADDR_W      = 4;    // register word address width
    localparam int FLD_W       = 4;    // routing field width
    localparam int LVL_N       = 7;    // general-purpose levels
    localparam int LVL_BASE    = 7;    // number of the lowest general level
    localparam int CNT_W       = 8;    // spurious counter width

    localparam int BANK_N      = SRC_N / BANK_W;
    localparam int FLD_PER_REG = DATA_W / FLD_W;
    localparam int ASGN_REGS   = SRC_N / FLD_PER_REG;
    localparam int SRC_IW      = $clog2(SRC_N);
    localparam int LVL_IW      = $clog2(LVL_N);

    // Register map (word addresses)
    localparam int MASK_BASE   = 0;
    localparam int STAT_BASE   = MASK_BASE + BANK_N;
    localparam int WAKE_BASE   = STAT_BASE + BANK_N;
    localparam int SPUR_ADDR   = WAKE_BASE + BANK_N;
    localparam int ASGN_BASE   = 8;
endpackage

// File: rtl/sip_regs.sv
// Module: register file of the mapper. Holds mask, wakeup-enable and routing
// registers, presents status from the live inputs and the spurious count.
// Assumes BANK_W == DATA_W and that the routing registers pack FLD_PER_REG
// fields each, so source n's field sits at flat bit n*FLD_W.
module sip_regs
    import sip_pkg::*;
#(
    parameter int P_SRC_N  = SRC_N,
    parameter int P_ADDR_W = ADDR_W,
    parameter int P_DATA_W = DATA_W,
    parameter int P_FLD_W  = FLD_W,
    parameter int P_CNT_W  = CNT_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we,
    input  logic [P_ADDR_W-1:0]         addr,
    input  logic [P_DATA_W-1:0]         wdata,
    input  logic [P_SRC_N-1:0]          src_in,
    input  logic [P_CNT_W-1:0]          spur_cnt,
    output logic [P_DATA_W-1:0]         rdata,
    output logic [P_SRC_N-1:0]          mask_vec,
    output logic [P_SRC_N*P_FLD_W-1:0]  fld_vec
);
    localparam int NB = P_SRC_N / P_DATA_W;
    localparam int NA = (P_SRC_N * P_FLD_W) / P_DATA_W;

    logic [NB-1:0][P_DATA_W-1:0] mask_q;
    logic [NB-1:0][P_DATA_W-1:0] wake_q;
    logic [NA-1:0][P_DATA_W-1:0] asgn_q;
    logic [NB-1:0][P_DATA_W-1:0] stat_w;

    assign stat_w   = src_in;
    assign mask_vec = mask_q;
    assign fld_vec  = asgn_q;

    for (genvar b = 0; b < NB; b++) begin : g_bank
        // Purpose: hold one mask bank, cleared on reset.
        always_ff @(posedge clk) begin
            if (!rst_n)
                mask_q[b] <= '0;
            else if (we && addr == P_ADDR_W'(MASK_BASE + b))
                mask_q[b] <= wdata;
        end
        // Purpose: hold one wakeup-enable bank, cleared on reset.
        always_ff @(posedge clk) begin
            if (!rst_n)
                wake_q[b] <= '0;
            else if (we && addr == P_ADDR_W'(WAKE_BASE + b))
                wake_q[b] <= wdata;
        end
    end

    for (genvar a = 0; a < NA; a++) begin : g_asgn
        // Purpose: hold one routing register of packed fields, cleared on reset.
        always_ff @(posedge clk) begin
            if (!rst_n)
                asgn_q[a] <= '0;
            else if (we && addr == P_ADDR_W'(ASGN_BASE + a))
                asgn_q[a] <= wdata;
        end
    end

    // Purpose: select the read data for the current address.
    always_comb begin
        rdata = '0;
        for (int b = 0; b < NB; b++) begin
            if (addr == P_ADDR_W'(MASK_BASE + b)) rdata = mask_q[b];
            if (addr == P_ADDR_W'(STAT_BASE + b)) rdata = stat_w[b];
            if (addr == P_ADDR_W'(WAKE_BASE + b)) rdata = wake_q[b];
        end
        for (int a = 0; a < NA; a++) begin
            if (addr == P_ADDR_W'(ASGN_BASE + a)) rdata = asgn_q[a];
        end
        if (addr == P_ADDR_W'(SPUR_ADDR)) rdata = P_DATA_W'(spur_cnt);
    end
endmodule

// File: rtl/sip_router.sv
// Module: per-level request generator. ORs every pending source into the
// request of the level its field selects; fields >= P_LVL_N select nothing.
// Output is registered (one cycle latency).
module sip_router
    import sip_pkg::*;
#(
    parameter int P_SRC_N = SRC_N,
    parameter int P_FLD_W = FLD_W,
    parameter int P_LVL_N = LVL_N
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [P_SRC_N-1:0]          pend,
    input  logic [P_SRC_N*P_FLD_W-1:0]  fld_vec,
    output logic [P_LVL_N-1:0]          req_q
);
    logic [P_LVL_N-1:0] hit;

    // Purpose: combine pending sources into per-level hits.
    always_comb begin
        hit = '0;
        for (int n = 0; n < P_SRC_N; n++) begin
            for (int k = 0; k < P_LVL_N; k++) begin
                if (pend[n] && fld_vec[n*P_FLD_W +: P_FLD_W] == P_FLD_W'(k))
                    hit[k] = 1'b1;
            end
        end
    end

    // Purpose: register the level requests.
    always_ff @(posedge clk) begin
        if (!rst_n)
            req_q <= '0;
        else
            req_q <= hit;
    end
endmodule

// File: rtl/sip_finder.sv
// Module: lookup resolver. For a queried level returns the lowest-numbered
// pending source routed to it, or a spurious flag. Purely combinational.
module sip_finder
    import sip_pkg::*;
#(
    parameter int P_SRC_N    = SRC_N,
    parameter int P_FLD_W    = FLD_W,
    parameter int P_LVL_N    = LVL_N,
    parameter int P_LVL_BASE = LVL_BASE
) (
    input  logic                        valid,
    input  logic [P_FLD_W-1:0]          level,
    input  logic [P_SRC_N-1:0]          pend,
    input  logic [P_SRC_N*P_FLD_W-1:0]  fld_vec,
    output logic                        found,
    output logic [$clog2(P_SRC_N)-1:0]  src_idx,
    output logic                        spurious
);
    logic [P_FLD_W-1:0] want;
    logic               in_range;
    logic               any;

    assign want     = level - P_FLD_W'(P_LVL_BASE);
    assign in_range = (level >= P_FLD_W'(P_LVL_BASE)) &&
                      (level <  P_FLD_W'(P_LVL_BASE + P_LVL_N));

    // Purpose: priority-encode, scanning downward so the lowest index wins.
    always_comb begin
        any     = 1'b0;
        src_idx = '0;
        for (int n = P_SRC_N - 1; n >= 0; n--) begin
            if (pend[n] && fld_vec[n*P_FLD_W +: P_FLD_W] == want) begin
                any     = 1'b1;
                src_idx = ($clog2(P_SRC_N))'(n);
            end
        end
    end

    assign found    = valid && in_range && any;
    assign spurious = valid && !found;
endmodule

// File: rtl/sip_mapper.sv
// Module: top of the interrupt priority mapper. Masks sources, routes them to
// levels, resolves lookups and counts spurious lookups (saturating).
// Assumes src_in is synchronous to clk.
module sip_mapper
    import sip_pkg::*;
#(
    parameter int P_SRC_N    = SRC_N,
    parameter int P_ADDR_W   = ADDR_W,
    parameter int P_DATA_W   = DATA_W,
    parameter int P_FLD_W    = FLD_W,
    parameter int P_LVL_N    = LVL_N,
    parameter int P_LVL_BASE = LVL_BASE,
    parameter int P_CNT_W    = CNT_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [P_SRC_N-1:0]           src_in,
    input  logic                         bus_we,
    input  logic [P_ADDR_W-1:0]          bus_addr,
    input  logic [P_DATA_W-1:0]          bus_wdata,
    output logic [P_DATA_W-1:0]          bus_rdata,
    output logic [P_LVL_N-1:0]           irq_req,
    input  logic                         lk_valid,
    input  logic [P_FLD_W-1:0]           lk_level,
    output logic                         lk_found,
    output logic [$clog2(P_SRC_N)-1:0]   lk_src,
    output logic                         lk_spurious
);
    logic [P_SRC_N-1:0]          mask_vec;
    logic [P_SRC_N*P_FLD_W-1:0]  fld_vec;
    logic [P_SRC_N-1:0]          pend;
    logic [P_CNT_W-1:0]          spur_cnt;

    assign pend = src_in & mask_vec;

    sip_regs #(
        .P_SRC_N(P_SRC_N), .P_ADDR_W(P_ADDR_W), .P_DATA_W(P_DATA_W),
        .P_FLD_W(P_FLD_W), .P_CNT_W(P_CNT_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr),
        .wdata(bus_wdata), .src_in(src_in), .spur_cnt(spur_cnt),
        .rdata(bus_rdata), .mask_vec(mask_vec), .fld_vec(fld_vec)
    );

    sip_router #(
        .P_SRC_N(P_SRC_N), .P_FLD_W(P_FLD_W), .P_LVL_N(P_LVL_N)
    ) u_router (
        .clk(clk), .rst_n(rst_n), .pend(pend), .fld_vec(fld_vec),
        .req_q(irq_req)
    );

    sip_finder #(
        .P_SRC_N(P_SRC_N), .P_FLD_W(P_FLD_W), .P_LVL_N(P_LVL_N),
        .P_LVL_BASE(P_LVL_BASE)
    ) u_finder (
        .valid(lk_valid), .level(lk_level), .pend(pend), .fld_vec(fld_vec),
        .found(lk_found), .src_idx(lk_src), .spurious(lk_spurious)
    );

    // Purpose: count spurious lookups, holding at all ones.
    always_ff @(posedge clk) begin
        if (!rst_n)
            spur_cnt <= '0;
        else if (lk_spurious && spur_cnt != {P_CNT_W{1'b1}})
            spur_cnt <= spur_cnt + 1'b1;
    end
endmodule

// File: rtl/sip_mapper_chk.sv
// Module: property checker for sip_mapper, attached by bind below.
// Assumes src_in is synchronous to clk and spur_cnt has no write path.
module sip_mapper_chk #(
    parameter int P_SRC_N    = 64,
    parameter int P_FLD_W    = 4,
    parameter int P_LVL_N    = 7,
    parameter int P_LVL_BASE = 7,
    parameter int P_CNT_W    = 8
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [P_SRC_N-1:0]          src_in,
    input logic [P_SRC_N-1:0]          mask_vec,
    input logic [P_LVL_N-1:0]          irq_req,
    input logic                        lk_valid,
    input logic [P_FLD_W-1:0]          lk_level,
    input logic                        lk_found,
    input logic [$clog2(P_SRC_N)-1:0]  lk_src,
    input logic                        lk_spurious,
    input logic [P_CNT_W-1:0]          spur_cnt
);
    logic [P_SRC_N-1:0] pend_c;
    assign pend_c = src_in & mask_vec;

    // R6 / R5: a request needs a pending source one cycle earlier
    p_req_needs_pend_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_req) |-> $past(|pend_c));

    // R7: a found source is really pending
    p_found_is_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
        lk_found |-> pend_c[lk_src]);

    // R8: with a lookup, exactly one of found / spurious
    p_found_xor_spur_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |-> (lk_found != lk_spurious));

    // R8: no lookup, no answer
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> (!lk_found && !lk_spurious));

    // R8: counter steps on a spurious lookup below saturation
    p_spur_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_spurious && spur_cnt != {P_CNT_W{1'b1}}) |=>
            (spur_cnt == $past(spur_cnt) + 1'b1));

    // R8: counter holds otherwise
    p_spur_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!lk_spurious || spur_cnt == {P_CNT_W{1'b1}}) |=> $stable(spur_cnt));

    // R12: out-of-range level is always spurious
    p_bad_level_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && (lk_level < P_FLD_W'(P_LVL_BASE) ||
                      lk_level >= P_FLD_W'(P_LVL_BASE + P_LVL_N)))
            |-> lk_spurious);
endmodule

bind sip_mapper sip_mapper_chk #(
    .P_SRC_N(P_SRC_N), .P_FLD_W(P_FLD_W), .P_LVL_N(P_LVL_N),
    .P_LVL_BASE(P_LVL_BASE), .P_CNT_W(P_CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .mask_vec(mask_vec),
    .irq_req(irq_req), .lk_valid(lk_valid), .lk_level(lk_level),
    .lk_found(lk_found), .lk_src(lk_src), .lk_spurious(lk_spurious),
    .spur_cnt(spur_cnt)
);

// File: tb/tb_sip_mapper.sv
// Directed bench for sip_mapper: one task per scenario, inputs driven and
// outputs sampled on the falling clock edge.
module tb_sip_mapper;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [63:0] src_in;
    logic        bus_we;
    logic [3:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [6:0]  irq_req;
    logic        lk_valid;
    logic [3:0]  lk_level;
    logic        lk_found;
    logic [5:0]  lk_src;
    logic        lk_spurious;

    int n_chk  = 0;
    int n_fail = 0;
    int spur_exp = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sip_mapper dut (
        .clk(clk), .rst_n(rst_n), .src_in(src_in), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_req(irq_req), .lk_valid(lk_valid), .lk_level(lk_level),
        .lk_found(lk_found), .lk_src(lk_src), .lk_spurious(lk_spurious)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic unroute_all();
        for (int a = 8; a < 16; a++) wr(4'(a), 32'hFFFF_FFFF);
    endtask

    // Lookup one cycle; checks the answer and the counter afterwards.
    task automatic lookup(input string tag, input logic [3:0] lvl,
                          input logic exp_found, input logic [5:0] exp_src);
        logic [31:0] d;
        lk_valid = 1'b1; lk_level = lvl;
        #1;
        check({tag, " found"}, lk_found, exp_found);
        check({tag, " spurious"}, lk_spurious, !exp_found);
        if (exp_found) check({tag, " src"}, lk_src, exp_src);
        @(negedge clk);
        lk_valid = 1'b0;
        if (!exp_found && spur_exp < 255) spur_exp++;
        rd(4'd6, d);
        check({tag, " count R8"}, d, spur_exp);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        for (int a = 0; a < 16; a++) begin
            if (a == 2 || a == 3 || a == 7) continue;
            rd(4'(a), d);
            check("R1 reset register", d, 0);
        end
        check("R1 reset requests", irq_req, 0);
    endtask

    task automatic t_banks();
        logic [31:0] d;
        src_in = 64'hA5A5_0001_8000_00C3;
        rd(4'd2, d); check("R11 status bank0", d, 32'h8000_00C3);
        rd(4'd3, d); check("R11 status bank1", d, 32'hA5A5_0001);
        wr(4'd2, 32'h0); wr(4'd3, 32'hFFFF_FFFF);
        rd(4'd2, d); check("R9 status write ignored", d, 32'h8000_00C3);
        rd(4'd3, d); check("R9 status write ignored b1", d, 32'hA5A5_0001);
        src_in = 64'h1;
        rd(4'd2, d); check("R9 status follows input", d, 32'h1);
        src_in = '0;
    endtask

    task automatic t_wake();
        logic [31:0] d;
        wr(4'd4, 32'hFFFF_FFFF); wr(4'd5, 32'hFFFF_FFFF);
        rd(4'd4, d); check("R10 wake0 all set", d, 32'hFFFF_FFFF);
        rd(4'd5, d); check("R10 wake1 all set", d, 32'hFFFF_FFFF);
        wr(4'd5, 32'h0);
        rd(4'd5, d); check("R10 wake1 clear", d, 0);
        check("R10 wake no request", irq_req, 0);
    endtask

    task automatic t_fields();
        logic [31:0] d;
        wr(4'd0, 32'hFFFF_FFFF); wr(4'd1, 32'hFFFF_FFFF);
        unroute_all();
        src_in = (64'h1 << 13) | (64'h1 << 45);
        @(negedge clk);
        check("R4 all unrouted", irq_req, 0);
        wr(4'd9, 32'hFF4F_FFFF);     // source 13 -> value 4 (level 11)
        @(negedge clk);
        check("R2 R3 source13 level11", irq_req, 7'b001_0000);
        wr(4'd13, 32'hFF6F_FFFF);    // source 45 -> value 6 (level 13)
        @(negedge clk);
        check("R2 R3 source45 level13", irq_req, 7'b101_0000);
        rd(4'd13, d); check("R2 routing readback", d, 32'hFF6F_FFFF);
        unroute_all();
        wr(4'd8, 32'hFFFF_FFF7);     // source 0 -> 7 (none)
        src_in = 64'h8000_0000_0000_0001;
        @(negedge clk);
        check("R4 values 7 and 15 unrouted", irq_req, 0);
        wr(4'd8, 32'hFFFF_FFF0);     // source 0 -> level 7
        @(negedge clk);
        check("R3 value0 level7", irq_req, 7'b000_0001);
        src_in = '0;
        @(negedge clk);
    endtask

    task automatic t_mask();
        logic [31:0] d;
        unroute_all();
        wr(4'd15, 32'h3FFF_FFFF);    // source 63 -> level 10
        wr(4'd1, 32'h0);
        src_in = 64'h8000_0000_0000_0000;
        @(negedge clk); @(negedge clk);
        check("R5 masked source silent", irq_req, 0);
        wr(4'd1, 32'h8000_0000);
        rd(4'd1, d); check("R11 mask bank1 bit31", d, 32'h8000_0000);
        @(negedge clk);
        check("R5 R11 unmasked source63", irq_req, 7'b000_1000);
        src_in = '0;
        @(negedge clk);
    endtask

    task automatic t_latency();
        wr(4'd0, 32'hFFFF_FFFF);
        wr(4'd8, 32'hFFFF_FFF0);
        src_in = 64'h1;
        #1 check("R6 no change before edge", irq_req, 0);
        @(negedge clk);
        check("R6 request after one edge", irq_req, 7'b000_0001);
        src_in = '0;
        #1 check("R6 holds before edge", irq_req, 7'b000_0001);
        @(negedge clk);
        check("R6 drops after one edge", irq_req, 0);
    endtask

    task automatic t_lookup();
        unroute_all();
        wr(4'd0, 32'hFFFF_FFFF); wr(4'd1, 32'hFFFF_FFFF);
        wr(4'd8, 32'hFF2F_FFFF);     // source 5 -> level 9
        wr(4'd13, 32'hFFFF_FFF2);    // source 40 -> level 9
        src_in = (64'h1 << 5) | (64'h1 << 40);
        lookup("R7 lowest of two", 4'd9, 1'b1, 6'd5);
        src_in = 64'h1 << 40;
        lookup("R7 only source40", 4'd9, 1'b1, 6'd40);
        lookup("R8 empty level10", 4'd10, 1'b0, 6'd0);
        wr(4'd1, 32'h0);
        lookup("R8 masked source", 4'd9, 1'b0, 6'd0);
        lookup("R12 level3", 4'd3, 1'b0, 6'd0);
        lookup("R12 level14", 4'd14, 1'b0, 6'd0);
    endtask

    task automatic t_saturate();
        logic [31:0] d;
        lk_valid = 1'b1; lk_level = 4'd12;
        repeat (300) @(negedge clk);
        lk_valid = 1'b0;
        spur_exp = 255;
        rd(4'd6, d); check("R8 counter saturates", d, 255);
        lookup("R8 stays saturated", 4'd12, 1'b0, 6'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; src_in = '0; bus_we = 1'b0; bus_addr = '0;
        bus_wdata = '0; lk_valid = 1'b0; lk_level = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_banks();
        t_wake();
        t_fields();
        t_mask();
        t_latency();
        t_lookup();
        t_saturate();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule